// File: doc/BRIEF.md
# Side-Channel Request/Reply Transaction Engine

This block runs one request/reply exchange on a DisplayPort-style AUX side channel. Software fills a transmit byte buffer with the request header and, for writes, the payload. It then writes the control register with a byte count and the GO bit. The engine streams exactly that many bytes to a serializer over a valid/ready byte handshake. It then waits for reply bytes, stores them in a receive buffer and raises DONE. The status word carries the reply byte count, the reply code, a timeout flag, a reject flag and sticky receive error flags.

The header is built by software: the command in the upper nibble of byte 0, address high then address low, and payload size minus one (omitted for zero-size requests). The engine enforces the size limit: a request longer than a 4-byte header plus 16 payload bytes, or a zero count, is refused without sending anything. The first reply byte is the ack byte, whose upper nibble is the reply code; any following bytes are data. Software pops reply bytes through the data register, one byte per read, unless the hold mode keeps the read position fixed. DONE stays set until software acknowledges it. A programmable reply timeout ends a transaction that gets no answer.

Register map (`reg_addr`): 0 control, 1 data, 2 status, 3 acknowledge, 4 timeout limit.

Top module: `aux_txn_engine`

## Requirements
- R1: After reset the status word reads 0 and `tx_valid` is low.
- R2: A control write with bit 8 (GO) set and a count N (bits 4:0) in the range 1..20, while idle, sends exactly the first N bytes loaded through data-register writes (bits 7:0), in load order, one per cycle in which `tx_valid` and `tx_ready` are both high; `tx_data` holds steady while `tx_ready` is low.
- R3: GO with a count of 0 or greater than 20 is refused: no byte is sent, and status bit 0 (DONE) and bit 3 (reject) are set at once with bit 1 (busy) clear.
- R4: A GO written while a transaction is busy is ignored; the running transaction sends exactly its original count.
- R5: Reply bytes are accepted only after the last request byte is sent. On `rx_last` the engine sets DONE. Status bits 28:24 give the number of reply bytes and bits 23:20 the upper nibble of the first reply byte.
- R6: Each read of the data register returns the next stored reply byte in bits 15:8. With control bit 12 (hold) set, reads return the same byte and do not advance.
- R7: If no reply byte arrives for the number of cycles in the timeout register (bits 15:0), DONE and status bit 2 (timeout) are set and the reply count reads 0.
- R8: Status bits 8:4 are the sticky OR of `rx_err` over the reply (bit 0 partial byte, bit 1 bad start, bit 2 bad stop, bit 3 bad sync, bit 4 short reply). Status bit 9 sets when a reply exceeds 17 bytes; the count then stays at 17.
- R9: DONE stays set until an acknowledge-register write with bit 0 set, or until a new GO is accepted.
- R10: An accepted GO clears the reply buffer and flags; the status then shows busy with a count of 0.
- R11: `rx_valid` while no transaction waits for a reply stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the reply buffer at the data address) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on the address |
| tx_valid | output | 1 | Request byte available to the serializer |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_data | output | 8 | Request byte |
| rx_valid | input | 1 | Reply byte present |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Marks the final reply byte |
| rx_err | input | 5 | Per-byte receive error flags |

## Verification
The scoreboard checks every serializer handshake against the bytes software loaded, so a design that resent a byte, dropped one during a `tx_ready` stall, or started a refused or busy-time GO shows up as a mismatch or as an unexpected byte. Reply corner cases come next. A stray `rx_valid` before GO must not count, or the reply count is off by one. Hold-mode reads must repeat, or the data order slips. A 17-byte buffer hit by 18 bytes must flag overflow rather than wrap. A timeout after a partial reply must report a zero count, not the partial one. DONE is checked to persist until acknowledged, which catches a design that clears it on a status read.

// File: rtl/aux_pkg.sv
package aux_pkg;

  localparam int unsigned CNT_FIELD_W = 5;
  localparam int unsigned RX_ERR_W    = 5;
  localparam int unsigned ERR_W       = RX_ERR_W + 1;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_DATA = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_ACK  = 3'd3;
  localparam logic [2:0] A_TMO  = 3'd4;

  localparam int unsigned CTRL_GO_BIT   = 8;
  localparam int unsigned CTRL_HOLD_BIT = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_t;

  // A request count is legal when it is non-zero and fits the header plus payload limit.
  function automatic logic count_refused(input logic [CNT_FIELD_W-1:0] cnt,
                                         input logic [CNT_FIELD_W-1:0] max_req);
    return (cnt == '0) || (cnt > max_req);
  endfunction

  function automatic logic [3:0] reply_code(input logic [7:0] ack_byte);
    return ack_byte[7:4];
  endfunction

  function automatic logic [31:0] pack_status(input logic done, input logic busy,
                                              input logic tmo, input logic rej,
                                              input logic [ERR_W-1:0] err,
                                              input logic [3:0] code,
                                              input logic [4:0] cnt);
    logic [31:0] w;
    w        = '0;
    w[0]     = done;
    w[1]     = busy;
    w[2]     = tmo;
    w[3]     = rej;
    w[9:4]   = err;
    w[23:20] = code;
    w[28:24] = cnt;
    return w;
  endfunction

endpackage

// File: rtl/aux_byte_buf.sv
module aux_byte_buf #(
  parameter int unsigned DEPTH = 20,
  localparam int unsigned PW = $clog2(DEPTH + 1),
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rewind,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  output logic [7:0]    dout,
  output logic [7:0]    head,
  output logic [PW-1:0] level,
  output logic          overflow
);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic          full, empty, do_push, do_pop;

  assign full     = (wptr_q == PW'(DEPTH));
  assign empty    = (rptr_q == wptr_q);
  assign do_push  = push && !full && !clr;
  assign do_pop   = pop && !empty && !clr && !rewind;
  assign overflow = push && full && !clr;
  assign level    = wptr_q;
  assign dout     = empty ? 8'h00 : mem[rptr_q[IW-1:0]];
  assign head     = (wptr_q == '0) ? 8'h00 : mem[0];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q[IW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (clr) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (rewind) rptr_q <= '0;
      else if (do_pop) rptr_q <= rptr_q + 1'b1;
    end
  end

  // R8: the fill level never passes the buffer size, even under excess pushes
  a_r8_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> (wptr_q == PW'(DEPTH)));

  // R6: the read position never runs ahead of the stored bytes
  a_r6_read_behind_write: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_q <= wptr_q);

endmodule

// File: rtl/aux_seq.sv
module aux_seq
  import aux_pkg::*;
#(
  parameter int unsigned MAX_REQ = 20,
  parameter int unsigned TMO_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go_req,
  input  logic [CNT_FIELD_W-1:0] go_cnt,
  input  logic                   ack_req,
  input  logic [TMO_W-1:0]       tmo_limit,
  input  logic                   tx_ready,
  input  logic                   rx_valid,
  input  logic                   rx_last,
  input  logic [RX_ERR_W-1:0]    rx_err,
  input  logic                   rx_ovf,
  output logic                   tx_valid,
  output logic                   tx_pop,
  output logic                   rx_push,
  output logic                   clr_tx,
  output logic                   clr_rx,
  output logic                   go_accept,
  output logic                   go_reject,
  output logic                   tmo_evt,
  output logic                   busy,
  output logic                   done,
  output logic                   tmo_flag,
  output logic                   rej_flag,
  output logic [ERR_W-1:0]       err_flags
);

  localparam logic [CNT_FIELD_W-1:0] MAX_CNT = CNT_FIELD_W'(MAX_REQ);

  seq_state_t             state_q;
  logic [CNT_FIELD_W-1:0] cnt_q, sent_q;
  logic [TMO_W-1:0]       timer_q;
  logic                   done_q, tmo_q, rej_q;
  logic [ERR_W-1:0]       err_q;
  logic                   idle, last_tx, reply_end, finish;

  assign idle      = (state_q == ST_IDLE);
  assign go_accept = go_req && idle && !count_refused(go_cnt, MAX_CNT);
  assign go_reject = go_req && idle &&  count_refused(go_cnt, MAX_CNT);
  assign tx_valid  = (state_q == ST_SEND);
  assign tx_pop    = tx_valid && tx_ready;
  assign last_tx   = tx_pop && (sent_q == cnt_q - 1'b1);
  assign rx_push   = (state_q == ST_WAIT) && rx_valid;
  assign reply_end = rx_push && rx_last;
  assign tmo_evt   = (state_q == ST_WAIT) && !rx_valid && (timer_q == tmo_limit);
  assign finish    = reply_end || tmo_evt;
  assign clr_rx    = go_accept || tmo_evt;
  assign clr_tx    = finish || go_reject;
  assign busy      = !idle;
  assign done      = done_q;
  assign tmo_flag  = tmo_q;
  assign rej_flag  = rej_q;
  assign err_flags = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sent_q  <= '0;
      timer_q <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      rej_q   <= 1'b0;
      err_q   <= '0;
    end else begin
      if (ack_req) done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (go_accept) begin
            state_q <= ST_SEND;
            cnt_q   <= go_cnt;
            sent_q  <= '0;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
            rej_q   <= 1'b0;
            err_q   <= '0;
          end else if (go_reject) begin
            done_q  <= 1'b1;
            rej_q   <= 1'b1;
            tmo_q   <= 1'b0;
            err_q   <= '0;
          end
        end
        ST_SEND: begin
          if (tx_pop) sent_q <= sent_q + 1'b1;
          if (last_tx) begin
            state_q <= ST_WAIT;
            timer_q <= '0;
          end
        end
        ST_WAIT: begin
          if (rx_push) begin
            timer_q <= '0;
            err_q   <= err_q | {rx_ovf, rx_err};
          end else if (!tmo_evt) begin
            timer_q <= timer_q + 1'b1;
          end
          if (finish) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            tmo_q   <= tmo_evt;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a refused GO leaves the engine idle with DONE raised and nothing offered
  a_r3_refused_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go_reject |=> (idle && done_q && rej_q && !tx_valid));

  // R4: a GO arriving mid-transaction leaves the latched count alone
  a_r4_busy_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && busy) |=> $stable(cnt_q));

  // R9: DONE persists until acknowledged or replaced by a new transaction
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ack_req && !go_accept) |=> done_q);

  // R7: the timeout flag never rises without DONE
  a_r7_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> done_q);

endmodule

// File: rtl/aux_txn_engine.sv
module aux_txn_engine
  import aux_pkg::*;
#(
  parameter int unsigned HDR_BYTES   = 4,
  parameter int unsigned MAX_PAYLOAD = 16,
  parameter int unsigned TMO_W       = 16,
  parameter int unsigned TMO_RESET   = 1000,
  localparam int unsigned MAX_REQ    = HDR_BYTES + MAX_PAYLOAD,
  localparam int unsigned RX_DEPTH   = MAX_PAYLOAD + 1,
  localparam int unsigned RX_PW      = $clog2(RX_DEPTH + 1),
  localparam int unsigned TX_PW      = $clog2(MAX_REQ + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic [4:0]  rx_err
);

  logic             hold_q;
  logic [TMO_W-1:0] tmo_q;
  logic             wr_ctrl, go_req, ack_req, tx_push, rx_pop;
  logic             tx_pop, rx_push, clr_tx, clr_rx, go_accept, go_reject, tmo_evt;
  logic             busy, done, tmo_flag, rej_flag, rx_ovf;
  logic [ERR_W-1:0] err_flags;
  logic [7:0]       rx_dout, rx_head, tx_head_unused;
  logic [RX_PW-1:0] rx_level;
  logic [TX_PW-1:0] tx_level_unused;
  logic             tx_ovf_unused;
  logic [3:0]       code;
  logic             unused_wbits;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign go_req  = wr_ctrl && reg_wdata[CTRL_GO_BIT];
  assign ack_req = reg_wr && (reg_addr == A_ACK) && reg_wdata[0];
  assign tx_push = reg_wr && (reg_addr == A_DATA) && !busy;
  assign rx_pop  = reg_rd && (reg_addr == A_DATA) && !hold_q;
  assign unused_wbits = ^{reg_wdata[31:16], tx_head_unused, tx_level_unused, tx_ovf_unused};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      tmo_q  <= TMO_W'(TMO_RESET);
    end else begin
      if (wr_ctrl) hold_q <= reg_wdata[CTRL_HOLD_BIT];
      if (reg_wr && (reg_addr == A_TMO)) tmo_q <= reg_wdata[TMO_W-1:0];
    end
  end

  aux_byte_buf #(.DEPTH(MAX_REQ)) u_tx_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_tx),
    .rewind   (go_accept),
    .push     (tx_push),
    .din      (reg_wdata[7:0]),
    .pop      (tx_pop),
    .dout     (tx_data),
    .head     (tx_head_unused),
    .level    (tx_level_unused),
    .overflow (tx_ovf_unused)
  );

  aux_byte_buf #(.DEPTH(RX_DEPTH)) u_rx_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_rx),
    .rewind   (1'b0),
    .push     (rx_push),
    .din      (rx_data),
    .pop      (rx_pop),
    .dout     (rx_dout),
    .head     (rx_head),
    .level    (rx_level),
    .overflow (rx_ovf)
  );

  aux_seq #(.MAX_REQ(MAX_REQ), .TMO_W(TMO_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_req    (go_req),
    .go_cnt    (reg_wdata[CNT_FIELD_W-1:0]),
    .ack_req   (ack_req),
    .tmo_limit (tmo_q),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_last   (rx_last),
    .rx_err    (rx_err),
    .rx_ovf    (rx_ovf),
    .tx_valid  (tx_valid),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .clr_tx    (clr_tx),
    .clr_rx    (clr_rx),
    .go_accept (go_accept),
    .go_reject (go_reject),
    .tmo_evt   (tmo_evt),
    .busy      (busy),
    .done      (done),
    .tmo_flag  (tmo_flag),
    .rej_flag  (rej_flag),
    .err_flags (err_flags)
  );

  assign code = reply_code(rx_head);

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {19'b0, hold_q, 12'b0};
      A_DATA:  reg_rdata = {16'b0, rx_dout, 8'b0};
      A_STAT:  reg_rdata = pack_status(done, busy, tmo_flag, rej_flag, err_flags,
                                       code, 5'(rx_level));
      A_TMO:   reg_rdata = 32'(tmo_q);
      default: reg_rdata = 32'b0;
    endcase
  end

  // R2: a stalled request byte stays offered and unchanged
  a_r2_stall_holds_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R7: a timeout leaves an empty reply buffer and DONE set
  a_r7_timeout_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (rx_level == '0) && done);

  // R11: reply bytes outside the waiting phase are not stored
  a_r11_stray_rx_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rx_valid && !go_accept) |=> $stable(rx_level));

  // R10: an accepted GO starts from an empty reply buffer
  a_r10_go_clears_reply: assert property (@(posedge clk) disable iff (!rst_n)
    go_accept |=> (rx_level == '0) && busy && !done);

endmodule

// File: tb/test_aux_txn_engine.sv
module test_aux_txn_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [4:0]  rx_err = '0;

  int unsigned n_cmp = 0, n_bad = 0;
  logic [7:0]  exp_q[$];
  logic [7:0]  rcnt = '0;
  bit          summary_done = 0;

  always #2.5 clk = ~clk;

  aux_txn_engine i_aux_txn_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err)
  );

  // Serializer model: stalls one cycle in three
  always @(posedge clk) rcnt <= rcnt + 8'd1;
  assign tx_ready = (rcnt % 3) != 8'd1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: every handshake must match the next byte the driver queued
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) check("R3/R4 unexpected tx byte", {24'b0, tx_data}, 32'hFFFF_FFFF);
      else check("R2 tx byte", {24'b0, tx_data}, {24'b0, exp_q.pop_front()});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // Driver: loads a byte into the engine and into the scoreboard
  task automatic load(input logic [7:0] b, input bit expect_tx);
    wr(3'd1, {24'b0, b});
    if (expect_tx) exp_q.push_back(b);
  endtask

  task automatic load_hdr(input logic [3:0] cmd, input logic [15:0] addr, input int size);
    load({cmd, 4'b0}, 1);
    load(addr[15:8], 1);
    load(addr[7:0], 1);
    if (size != 0) load(8'(size - 1), 1);
  endtask

  task automatic go(input int cnt, input bit hold);
    wr(3'd0, (32'(hold) << 12) | 32'h100 | 32'(cnt));
  endtask

  task automatic rx_byte(input logic [7:0] b, input bit last, input logic [4:0] e);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_last = last; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = '0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 1000) begin @(negedge clk); guard++; end
    check("R2 all bytes sent", 32'(exp_q.size()), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 400; i++) begin
      rd(3'd2, st);
      if (st[0]) break;
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] st, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd2, st);
    check("R1 status after reset", st, 32'h0);
    check("R1 tx_valid after reset", {31'b0, tx_valid}, 0);
    wr(3'd4, 32'd20);

    // Write request, 3-byte payload, 7 bytes in total
    load_hdr(4'h8, 16'h1234, 3);
    load(8'hD0, 1); load(8'hD1, 1); load(8'hD2, 1);
    go(7, 0);
    go(2, 0); // R4: busy, must be ignored
    rd(3'd2, st);
    check("R10 busy after GO", {30'b0, st[1], st[0]}, 32'h2);
    drain();
    rx_byte(8'h00, 1, 5'h0);
    wait_done(st);
    check("R5 done and count 1", {st[28:24], st[0]}, {5'd1, 1'b1});
    check("R4 no extra bytes after busy GO", 32'(exp_q.size()), 0);
    repeat (10) @(negedge clk);
    rd(3'd2, st);
    check("R9 DONE persists before ack", {31'b0, st[0]}, 1);
    wr(3'd3, 32'h1);
    rd(3'd2, st);
    check("R9 DONE cleared by ack", {31'b0, st[0]}, 0);

    // R11 stray reply byte while idle, then a 4-byte read request
    rx_byte(8'hEE, 1, 5'h1f);
    load_hdr(4'h9, 16'h0010, 4);
    go(4, 0);
    rd(3'd2, st);
    check("R10 count cleared on GO", {27'b0, st[28:24]}, 0);
    drain();
    rx_byte(8'h10, 0, 0); rx_byte(8'hA1, 0, 0); rx_byte(8'hA2, 0, 0);
    rx_byte(8'hA3, 0, 0); rx_byte(8'hA4, 1, 0);
    wait_done(st);
    check("R5 R11 reply count 5", {27'b0, st[28:24]}, 5);
    check("R5 reply code 1", {28'b0, st[23:20]}, 1);
    check("R8 no error flags", {26'b0, st[9:4]}, 0);
    rd(3'd1, d); check("R6 ack byte in 15:8", d, 32'h1000);
    wr(3'd0, 32'h1000);
    rd(3'd1, d); check("R6 hold read 1", d, 32'hA100);
    rd(3'd1, d); check("R6 hold read 2", d, 32'hA100);
    wr(3'd0, 32'h0);
    for (int k = 1; k <= 4; k++) begin
      rd(3'd1, d);
      check("R6 data byte", d, {16'b0, 8'(8'hA0 + k), 8'b0});
    end

    // Zero-size request: 3 header bytes only
    load_hdr(4'h9, 16'hBEEF, 0);
    go(3, 0);
    drain();
    rx_byte(8'h20, 0, 5'b00010); rx_byte(8'h55, 1, 5'b10000);
    wait_done(st);
    check("R5 code 2 count 2", {st[28:24], st[23:20]}, {5'd2, 4'd2});
    check("R8 sticky error flags", {26'b0, st[9:4]}, {26'b0, 6'b010010});

    // R3 refused counts
    load(8'h11, 0); load(8'h22, 0);
    go(21, 0);
    rd(3'd2, st);
    check("R3 count 21 refused", st[3:0], 4'b1001);
    repeat (10) @(negedge clk);
    wr(3'd3, 32'h1);
    go(0, 0);
    rd(3'd2, st);
    check("R3 count 0 refused", st[3:0], 4'b1001);
    wr(3'd3, 32'h1);

    // R8 overflow: 18 reply bytes into a 17-byte buffer
    load_hdr(4'h9, 16'h0200, 0);
    go(3, 0);
    drain();
    for (int k = 0; k < 18; k++) rx_byte(8'(k), k == 17, 0);
    wait_done(st);
    check("R8 overflow flag", {31'b0, st[9]}, 1);
    check("R8 count held at 17", {27'b0, st[28:24]}, 17);

    // R7 timeout after a partial reply
    load_hdr(4'h9, 16'h0300, 0);
    go(3, 0);
    drain();
    rx_byte(8'h00, 0, 0);
    repeat (60) @(negedge clk);
    rd(3'd2, st);
    check("R7 timeout with done", {st[2], st[1], st[0]}, 3'b101);
    check("R7 count zero on timeout", {27'b0, st[28:24]}, 0);

    finish_run();
  end

endmodule